// File: doc/BRIEF.md
# I/Q Pair Byte-Lane Transmitter with Forwarded Strobe Clock

This block carries a stream of complex samples, each an in-phase word and a quadrature word of 24 bits, across a narrow board-to-board link made of eight data lines plus one clock line. Every pair is cut into six byte-wide beats. Each beat is launched with one pulse of a forwarded clock. The receiver needs nothing else: there is no header, no marker and no flow-control wire. The far end knows a beat is valid only because a clock edge arrived with it. Between bursts the forwarded clock rests low, so an idle link shows no edges at all.

Samples enter through a valid/ready handshake into a one-entry holding slot. A small sequencer takes a pair from the slot and walks it out beat by beat. Each beat spends one system-clock cycle with the forwarded clock low and the new byte on the lines, then one cycle with the clock high. The byte therefore changes only on the falling edge and sits still across the rising edge. When the slot already holds the next pair at the end of a pair, the next pair starts on the very next cycle, with no gap in the edge train. A fresh pair can be accepted in the same cycle the slot is emptied, so a producer that keeps offering data is never held off for longer than needed.

Top module: `iq_byte_link_tx`

## Requirements
- R1: After reset, `lane_clk` is low, `lane_data` is 0 and `in_ready` is high.
- R2: Each accepted pair appears as six beats in the order I[23:16], I[15:8], I[7:0], Q[23:16], Q[15:8], Q[7:0]. The value of each beat is the value on `lane_data` at the rising edge of `lane_clk`.
- R3: Every beat gives exactly one rising edge of `lane_clk`. `lane_clk` stays high for exactly one system clock cycle, and an accepted pair produces exactly six pulses.
- R4: `lane_data` never changes in the cycle where `lane_clk` rises. A new byte is placed only while `lane_clk` is low.
- R5: When the next pair is already waiting as a pair finishes, the beats of the two pairs follow without a gap. Consecutive rising edges of `lane_clk` are two system clock cycles apart across the pair boundary.
- R6: With no pair waiting or in flight, `lane_clk` stays low and gives no edge.
- R7: `in_ready` is high when the holding slot is empty, and also in the cycle in which the sequencer empties it. Each handshake (`in_valid` and `in_ready` high at a clock edge) is delivered exactly once, with no loss and no duplication, even when the input is offered back to back.
- R8: Starting from an idle link, a pair accepted at clock edge k raises `lane_clk` at edge k+2, and its first byte is on `lane_data` from edge k+1.
- R9: `in_valid` asserted while `in_ready` is low has no effect. The data offered then never reaches `lane_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; two cycles make one beat |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a sample pair |
| in_i | input | 24 | In-phase word of the offered pair |
| in_q | input | 24 | Quadrature word of the offered pair |
| in_ready | output | 1 | Holding slot can take a pair at this edge |
| lane_data | output | 8 | Byte lines of the link |
| lane_clk | output | 1 | Forwarded clock, pulses once per beat, idle low |

## Verification
Two things can happen in the same clock edge: the holding slot hands its pair to the sequencer, and the slot captures a new pair from the producer. This happens at the start of the first pair from idle and at every pair boundary of a continuous stream. To provoke it, the bench offers sixteen pairs with `in_valid` held high throughout. It then judges the result at the link: every byte must arrive in order, exactly once, and the rising edges must stay two cycles apart across every boundary. A second test fills the slot and then drives junk data while `in_ready` is low. The junk must never appear on the lines.

// File: rtl/iqtx_pkg.sv
package iqtx_pkg;

  // Half-beat phase of the forwarded clock
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } fclk_phase_e;

  // Number of lane beats needed for one pair of words
  function automatic int beats_per_pair(input int word_w, input int lane_w);
    return (2 * word_w + lane_w - 1) / lane_w;
  endfunction

endpackage

// File: rtl/iqtx_hold_slot.sv
module iqtx_hold_slot #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         rd_take,
  output logic         slot_full,
  output logic [W-1:0] slot_data,
  output logic         wr_ready
);

  logic         full_q;
  logic [W-1:0] data_q;
  logic         wr_fire;

  // Free when empty, or when the reader drains it at this same edge
  assign wr_ready  = !full_q || rd_take;
  assign wr_fire   = wr_valid && wr_ready;
  assign slot_full = full_q;
  assign slot_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_fire) begin
        full_q <= 1'b1;
        data_q <= wr_data;
      end else if (rd_take) begin
        full_q <= 1'b0;
      end
    end
  end

  // R7
  slot_take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |-> full_q);

  // R7
  slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (full_q && data_q == $past(wr_data)));

  // R9
  slot_hold_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rd_take) |=> (full_q && $stable(data_q)));

endmodule

// File: rtl/iqtx_beat_seq.sv
module iqtx_beat_seq
  import iqtx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_full,
  input  logic [2*WORD_W-1:0] slot_data,
  output logic                take,
  output logic                busy,
  output logic                pair_end,
  output logic [LANE_W-1:0]   lane_data,
  output logic                lane_clk
);

  localparam int PAIR_W = 2 * WORD_W;
  localparam int BEATS  = beats_per_pair(WORD_W, LANE_W);
  localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  // Leading beat of a word, most significant lane first
  function automatic logic [LANE_W-1:0] head_beat(input logic [PAIR_W-1:0] w);
    return w[PAIR_W-1 -: LANE_W];
  endfunction

  // Word after the leading beat has been sent
  function automatic logic [PAIR_W-1:0] drop_beat(input logic [PAIR_W-1:0] w);
    return w << LANE_W;
  endfunction

  logic              busy_q;
  fclk_phase_e       phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PAIR_W-1:0] shreg_q;
  logic [LANE_W-1:0] data_q;
  logic              fclk_q;

  logic beat_end;
  logic last_beat;

  assign beat_end  = busy_q && (phase_q == PH_HIGH);
  assign last_beat = (idx_q == LAST_IDX);
  assign pair_end  = beat_end && last_beat;
  assign take      = slot_full && (!busy_q || pair_end);

  assign busy      = busy_q;
  assign lane_data = data_q;
  assign lane_clk  = fclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= PH_LOW;
      idx_q   <= '0;
      shreg_q <= '0;
      data_q  <= '0;
      fclk_q  <= 1'b0;
    end else if (take) begin
      busy_q  <= 1'b1;
      phase_q <= PH_LOW;
      idx_q   <= '0;
      data_q  <= head_beat(slot_data);
      shreg_q <= drop_beat(slot_data);
      fclk_q  <= 1'b0;
    end else if (busy_q && phase_q == PH_LOW) begin
      phase_q <= PH_HIGH;
      fclk_q  <= 1'b1;
    end else if (beat_end) begin
      phase_q <= PH_LOW;
      fclk_q  <= 1'b0;
      if (!last_beat) begin
        idx_q   <= idx_q + 1'b1;
        data_q  <= head_beat(shreg_q);
        shreg_q <= drop_beat(shreg_q);
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  // R3
  fclk_single_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fclk_q) |=> !fclk_q);

  // R4
  data_still_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fclk_q) |-> $stable(data_q));

  // R6
  idle_fclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !fclk_q);

  // R5
  seamless_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_end && slot_full) |=> (busy_q && idx_q == '0 && !fclk_q));

endmodule

// File: rtl/iq_byte_link_tx.sv
module iq_byte_link_tx #(
  parameter int SAMPLE_W = 24,
  parameter int LANE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  output logic                in_ready,
  output logic [LANE_W-1:0]   lane_data,
  output logic                lane_clk
);

  localparam int PAIR_W = 2 * SAMPLE_W;

  logic              slot_full;
  logic [PAIR_W-1:0] slot_data;
  logic              seq_take;
  logic              seq_busy;
  logic              seq_pair_end;
  logic              accept;

  assign accept = in_valid && in_ready;

  iqtx_hold_slot #(
    .W(PAIR_W)
  ) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (in_valid),
    .wr_data   ({in_i, in_q}),
    .rd_take   (seq_take),
    .slot_full (slot_full),
    .slot_data (slot_data),
    .wr_ready  (in_ready)
  );

  iqtx_beat_seq #(
    .WORD_W(SAMPLE_W),
    .LANE_W(LANE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_full (slot_full),
    .slot_data (slot_data),
    .take      (seq_take),
    .busy      (seq_busy),
    .pair_end  (seq_pair_end),
    .lane_data (lane_data),
    .lane_clk  (lane_clk)
  );

  // R8
  first_beat_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !seq_busy && !slot_full) |=> (seq_take && !lane_clk));

  // R7
  ready_while_draining_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_full && seq_busy && !seq_pair_end) |-> !in_ready);

endmodule

// File: tb/iq_byte_link_tx_tb.sv
module iq_byte_link_tx_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_i;
  logic [23:0] in_q;
  logic        in_ready;
  logic [7:0]  lane_data;
  logic        lane_clk;

  iq_byte_link_tx u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .in_ready  (in_ready),
    .lane_data (lane_data),
    .lane_clk  (lane_clk)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int pulses   = 0;
  int pairs    = 0;
  int acc_cyc  = 0;
  int rise_cyc = 0;
  bit have_rise = 0;
  bit stream_mode = 0;
  bit lat_armed = 0;
  bit prev_clk = 0;
  logic [7:0] prev_data = '0;
  logic [7:0] exp_q[$];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Expected byte k of a pair, computed arithmetically
  function automatic logic [7:0] beat_of(input logic [23:0] i, input logic [23:0] q, input int k);
    logic [23:0] w;
    w = (k < 3) ? i : q;
    return 8'((w >> (8 * (2 - (k % 3)))) & 24'hFF);
  endfunction

  // Called at a negedge; returns at the negedge after the handshake edge
  task automatic send(input logic [23:0] i, input logic [23:0] q);
    bit rdy;
    in_valid = 1'b1;
    in_i = i;
    in_q = q;
    do begin
      rdy = in_ready;
      if (rdy) acc_cyc = cyc + 1;
      @(negedge clk);
    end while (!rdy);
    in_valid = 1'b0;
    pairs++;
    for (int k = 0; k < 6; k++) exp_q.push_back(beat_of(i, q, k));
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Link monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (lane_clk && !prev_clk) begin
        pulses++;
        // R4 byte unchanged at the rising edge
        chk(lane_data == prev_data, "R4", lane_data, prev_data);
        if (exp_q.size() == 0) begin
          // R6 an edge with nothing to send
          chk(1'b0, "R6", 1, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          // R2 beat order and value
          chk(lane_data == e, "R2", lane_data, e);
        end
        if (stream_mode && have_rise)
          chk(cyc - rise_cyc == 2, "R5", cyc - rise_cyc, 2);
        if (lat_armed) begin
          chk(cyc == acc_cyc + 2, "R8", cyc - acc_cyc, 2);
          lat_armed = 0;
        end
        rise_cyc = cyc;
        have_rise = 1;
      end
      if (!lane_clk && prev_clk)
        chk(cyc - rise_cyc == 1, "R3", cyc - rise_cyc, 1);
      prev_clk = lane_clk;
      prev_data = lane_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    logic [23:0] lfsr;
    int pulses_before;
    bit saw_low;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_i = '0;
    in_q = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lane_clk == 1'b0, "R1", lane_clk, 0);
    chk(lane_data == 8'h00, "R1", lane_data, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 latency from idle, also first-byte position
    lat_armed = 1;
    send(24'hA5C3F0, 24'h0F1E2D);
    drain();
    chk(lat_armed == 0, "R8", lat_armed, 0);

    // R2 walking-one sweep over all 48 bit positions with varied gaps
    for (int b = 0; b < 48; b++) begin
      send((b < 24) ? (24'h1 << b) : 24'h0, (b >= 24) ? (24'h1 << (b - 24)) : 24'h0);
      repeat (b % 14) @(negedge clk);
    end
    drain();

    // R5 R7 continuous offering: slot refilled in the edge it is emptied
    stream_mode = 1;
    have_rise = 0;
    lfsr = 24'h5A17C3;
    saw_low = 0;
    for (int n = 0; n < 16; n++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      if (!in_ready) saw_low = 1;
      send(lfsr, ~lfsr ^ 24'h00FF00);
    end
    drain();
    stream_mode = 0;
    chk(saw_low == 1'b1, "R7", saw_low, 1);

    // R9 junk offered while not ready is dropped
    send(24'h111111, 24'h222222);
    send(24'h333333, 24'h444444);
    for (int n = 0; n < 30; n++) begin
      if (in_ready) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_i = 24'hDEAD00 + 24'(n);
        in_q = 24'hBEEF00 + 24'(n);
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);

    // R6 idle link shows no edges
    pulses_before = pulses;
    for (int n = 0; n < 20; n++) begin
      if (lane_clk) chk(1'b0, "R6", 1, 0);
      @(negedge clk);
    end
    chk(pulses == pulses_before, "R6", pulses - pulses_before, 0);

    // R3 R7 six pulses per accepted pair, none lost or duplicated
    chk(pulses == 6 * pairs, "R3", pulses, 6 * pairs);
    finish_run();
  end

endmodule